// File: doc/BRIEF.md
# Vetoed Coincidence Trigger Generator

This block turns a bank of discriminator pulses into a detector trigger. Each channel input is gated by its own enable bit, and the surviving channels are ORed together. Two photomultiplier inputs form a second term, combined either by AND or by OR, which may also start a trigger when software allows it. A trigger is emitted as a one-cycle pulse on the rising edge of this qualified OR, but only while triggering is enabled and no veto is present. The veto output is the OR of an external dead-time signal, two converter busy signals and the trigger pulse itself, so a trigger always blocks itself.

A downscaler thins the accepted triggers: with factor N it emits one readout pulse for every N triggers. A small write-only register port sets the control bits, the channel mask and the downscale factor. All detector and busy inputs are asynchronous and pass through two-flop synchronizers.

A trigger control state machine has three states. ARMED waits for the qualified OR; when it rises it moves to FIRE if triggering is enabled and the synchronized external veto is low, and to HOLD otherwise. FIRE drives the trigger for one cycle and goes to HOLD if the OR is still high, or back to ARMED if it has fallen. HOLD returns to ARMED once the OR is low. A rising edge that is blocked is therefore lost, not delayed.

Top module: `veto_trig_gen`

## Requirements
- R1: Channel i joins the OR only while bit i of the mask register (address 1) is 1; a masked channel produces neither `trig_raw` nor `trig_out`.
- R2: `trig_raw` is a one-cycle pulse on each rising edge of the OR of the enabled channels alone, regardless of the enable bit, the veto and the photomultiplier term; a channel rising before clock edge k shows on `trig_raw` after edge k+2.
- R3: `trig_out` is produced only while bit 10 of the control register (address 0) is 1.
- R4: If any of `dead_in`, `adc_busy` or `qdc_busy` is asserted (after synchronization) when the qualified OR rises, no trigger is produced for that rising edge, even if the veto ends while the OR stays high.
- R5: `veto_out` is the OR of the synchronized `dead_in`, `adc_busy` and `qdc_busy` and of `trig_out`.
- R6: Control bit 4 chooses how the photomultipliers combine: 0 requires both `pmt_a` and `pmt_b`, 1 accepts either.
- R7: The photomultiplier term can start a trigger only while control bit 5 is 1.
- R8: `trig_out` is a single-cycle pulse, one per rising edge of the qualified OR, appearing after edge k+2 when the input rises before edge k; a held input gives one pulse.
- R9: The downscale factor N is the low 16 bits of address 2; `trig_ds` pulses one cycle after every Nth `trig_out` pulse, and after every pulse when N is 0 or 1.
- R10: Writing the control register with bit 2 set clears the downscale count, so counting restarts; the bit is a strobe and is not stored.
- R11: After reset all outputs are low, the control register is 0, the mask is all ones and the downscale factor is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_in | input | NUM_CH | Discriminator channel inputs |
| pmt_a | input | 1 | First photomultiplier input |
| pmt_b | input | 1 | Second photomultiplier input |
| dead_in | input | 1 | External dead-time veto |
| adc_busy | input | 1 | ADC busy veto |
| qdc_busy | input | 1 | QDC busy veto |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address: 0 control, 1 mask, 2 downscale |
| wr_data | input | DATA_W | Register write data |
| trig_raw | output | 1 | Edge pulse of the enabled channel OR |
| trig_out | output | 1 | Accepted trigger pulse |
| trig_ds | output | 1 | Downscaled trigger pulse |
| veto_out | output | 1 | Combined veto |

## Verification
On every cycle the assertions check that a trigger lasts one cycle, that it only follows a cycle with triggering enabled, that a synchronized external veto or a quiet qualified OR keeps the next cycle free of triggers, and that a downscaled pulse always follows a trigger and a clear leaves the count at zero. Only the bench scenarios show the counting behaviour: that a blocked edge is lost even when the veto ends while the input stays high, how the photomultiplier AND/OR choice and the allow bit combine, that exactly one downscaled pulse arrives per N triggers, and that a clear strobe restarts the count.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_FIRE  = 2'd1,
        ST_HOLD  = 2'd2
    } trig_state_e;

    localparam int unsigned REG_CTRL  = 0;
    localparam int unsigned REG_MASK  = 1;
    localparam int unsigned REG_SCALE = 2;

    localparam int unsigned BIT_ENABLE    = 10;
    localparam int unsigned BIT_PMT_ALLOW = 5;
    localparam int unsigned BIT_PMT_OR    = 4;
    localparam int unsigned BIT_DS_CLR    = 2;
endpackage

// File: rtl/vtg_sync.sv
module vtg_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/vtg_regs.sv
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int unsigned NUM_CH = 17,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DS_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              en_o,
    output logic              pmt_allow_o,
    output logic              pmt_or_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic [DS_W-1:0]   factor_o,
    output logic              ds_clr_o
);
    logic sel_ctrl, sel_mask, sel_scale;
    logic unused_bits;

    assign sel_ctrl  = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
    assign sel_mask  = wr_en && (wr_addr == ADDR_W'(REG_MASK));
    assign sel_scale = wr_en && (wr_addr == ADDR_W'(REG_SCALE));
    assign unused_bits = ^wr_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o        <= 1'b0;
            pmt_allow_o <= 1'b0;
            pmt_or_o    <= 1'b0;
            mask_o      <= '1;
            factor_o    <= DS_W'(1);
        end else begin
            if (sel_ctrl) begin
                en_o        <= wr_data[BIT_ENABLE];
                pmt_allow_o <= wr_data[BIT_PMT_ALLOW];
                pmt_or_o    <= wr_data[BIT_PMT_OR];
            end
            if (sel_mask)  mask_o   <= wr_data[NUM_CH-1:0];
            if (sel_scale) factor_o <= wr_data[DS_W-1:0];
        end
    end

    // Strobe only: the clear bit is never held in a register.
    assign ds_clr_o = sel_ctrl && wr_data[BIT_DS_CLR];
endmodule

// File: rtl/vtg_prescale.sv
module vtg_prescale #(
    parameter int unsigned DS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire_i,
    input  logic            clr_i,
    input  logic [DS_W-1:0] factor_i,
    output logic            ds_o
);
    logic [DS_W-1:0] cnt_q;
    logic            pass_all;
    logic            emit;

    assign pass_all = (factor_i <= DS_W'(1));
    assign emit     = fire_i && (pass_all || (cnt_q >= factor_i - DS_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ds_o  <= 1'b0;
        end else begin
            ds_o <= emit;
            if (clr_i)       cnt_q <= '0;
            else if (emit)   cnt_q <= '0;
            else if (fire_i) cnt_q <= cnt_q + DS_W'(1);
        end
    end

    p_ds_follows_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ds_o |-> $past(fire_i));
    p_clear_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/veto_trig_gen.sv
module veto_trig_gen
    import vtg_pkg::*;
#(
    parameter int unsigned NUM_CH = 17,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DS_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_in,
    input  logic              pmt_a,
    input  logic              pmt_b,
    input  logic              dead_in,
    input  logic              adc_busy,
    input  logic              qdc_busy,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              trig_raw,
    output logic              trig_out,
    output logic              trig_ds,
    output logic              veto_out
);
    localparam int unsigned SYNC_W = NUM_CH + 5;

    logic [SYNC_W-1:0] sync_bus;
    logic [NUM_CH-1:0] chan_s;
    logic              pa_s, pb_s;
    logic [2:0]        ext_s;

    logic              en, pmt_allow, pmt_or, ds_clr;
    logic [NUM_CH-1:0] mask;
    logic [DS_W-1:0]   factor;

    logic chan_hit, pmt_term, hit, chan_hit_q;
    trig_state_e state_q, state_d;

    vtg_sync #(.W(SYNC_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({chan_in, pmt_a, pmt_b, dead_in, adc_busy, qdc_busy}),
        .sync_o  (sync_bus)
    );
    assign {chan_s, pa_s, pb_s, ext_s} = sync_bus;

    vtg_regs #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DS_W(DS_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .en_o        (en),
        .pmt_allow_o (pmt_allow),
        .pmt_or_o    (pmt_or),
        .mask_o      (mask),
        .factor_o    (factor),
        .ds_clr_o    (ds_clr)
    );

    assign chan_hit = |(chan_s & mask);
    assign pmt_term = pmt_or ? (pa_s | pb_s) : (pa_s & pb_s);
    assign hit      = chan_hit | (pmt_allow & pmt_term);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (hit) state_d = (en && !(|ext_s)) ? ST_FIRE : ST_HOLD;
            ST_FIRE:  state_d = hit ? ST_HOLD : ST_ARMED;
            ST_HOLD:  if (!hit) state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    // Outputs
    always_comb begin
        trig_out = (state_q == ST_FIRE);
        veto_out = (|ext_s) | trig_out;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_hit_q <= 1'b0;
            trig_raw   <= 1'b0;
        end else begin
            chan_hit_q <= chan_hit;
            trig_raw   <= chan_hit && !chan_hit_q;
        end
    end

    vtg_prescale #(.DS_W(DS_W)) u_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (trig_out),
        .clr_i    (ds_clr),
        .factor_i (factor),
        .ds_o     (trig_ds)
    );

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |=> !trig_out);
    p_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig_out |-> $past(en));
    p_veto_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|ext_s) |=> !trig_out);
    p_quiet_or_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !trig_out);
endmodule

// File: tb/veto_trig_gen_tb_top.sv
module veto_trig_gen_tb_top;
    localparam int NCH = 17;
    localparam logic [31:0] C_EN = 32'h400, C_PA = 32'h20, C_POR = 32'h10, C_CLR = 32'h4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] chan_in = '0;
    logic pmt_a = 0, pmt_b = 0, dead_in = 0, adc_busy = 0, qdc_busy = 0;
    logic wr_en = 0;
    logic [1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic trig_raw, trig_out, trig_ds, veto_out;

    int compared = 0, mismatched = 0, cyc = 0;
    int n_raw = 0, n_trig = 0, n_ds = 0;

    always #5 clk = ~clk;

    veto_trig_gen dut_i (
        .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .pmt_a(pmt_a), .pmt_b(pmt_b),
        .dead_in(dead_in), .adc_busy(adc_busy), .qdc_busy(qdc_busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .trig_raw(trig_raw), .trig_out(trig_out), .trig_ds(trig_ds), .veto_out(veto_out)
    );

    // Behavioural reference: two-cycle input delay, edge detection, counting.
    logic [NCH-1:0] m_ch1, m_ch2, m_mask;
    logic m_pa1, m_pa2, m_pb1, m_pb2, m_en, m_pallow, m_por, m_hprev, m_rprev;
    logic [2:0] m_x1, m_x2;
    int m_factor, m_cnt;
    logic e_raw, e_trig, e_ds, e_veto;

    always @(posedge clk) begin
        logic rawc, hitc, ptc, n_raw_e, n_trig_e, n_ds_e;
        if (!rst_n) begin
            m_ch1 = '0; m_ch2 = '0; m_mask = '1;
            m_pa1 = 0; m_pa2 = 0; m_pb1 = 0; m_pb2 = 0; m_x1 = '0; m_x2 = '0;
            m_en = 0; m_pallow = 0; m_por = 0; m_hprev = 0; m_rprev = 0;
            m_factor = 1; m_cnt = 0;
            e_raw = 0; e_trig = 0; e_ds = 0; e_veto = 0;
        end else begin
            rawc = |(m_ch2 & m_mask);
            ptc  = m_por ? (m_pa2 | m_pb2) : (m_pa2 & m_pb2);
            hitc = rawc | (m_pallow & ptc);
            n_raw_e  = rawc && !m_rprev;
            n_trig_e = hitc && !m_hprev && m_en && (m_x2 == 3'b000);
            n_ds_e   = 0;
            if (e_trig) begin
                if (m_factor <= 1) n_ds_e = 1;
                else if (m_cnt + 1 >= m_factor) begin n_ds_e = 1; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
            m_rprev = rawc; m_hprev = hitc;
            m_ch2 = m_ch1; m_ch1 = chan_in;
            m_pa2 = m_pa1; m_pa1 = pmt_a;
            m_pb2 = m_pb1; m_pb1 = pmt_b;
            m_x2 = m_x1;   m_x1 = {dead_in, adc_busy, qdc_busy};
            if (wr_en) begin
                case (wr_addr)
                    2'd0: begin
                        m_en = wr_data[10]; m_pallow = wr_data[5]; m_por = wr_data[4];
                        if (wr_data[2]) m_cnt = 0;
                    end
                    2'd1: m_mask = wr_data[NCH-1:0];
                    2'd2: m_factor = int'(wr_data[15:0]);
                    default: ;
                endcase
            end
            e_raw = n_raw_e; e_trig = n_trig_e; e_ds = n_ds_e;
            e_veto = (m_x2 != 3'b000) || n_trig_e;
        end
    end

    task automatic cmp(string tag, logic act, logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
        end
    endtask

    task automatic check(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            cmp("R2 trig_raw", trig_raw, e_raw);
            cmp("R8 trig_out", trig_out, e_trig);
            cmp("R9 trig_ds", trig_ds, e_ds);
            cmp("R5 veto_out", veto_out, e_veto);
            if (trig_raw) n_raw++;
            if (trig_out) n_trig++;
            if (trig_ds)  n_ds++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic zero_counts();
        @(posedge clk); n_raw = 0; n_trig = 0; n_ds = 0;
    endtask

    task automatic hit(input logic [NCH-1:0] ch, input logic pa, input logic pb, input int len);
        @(negedge clk); chan_in = ch; pmt_a = pa; pmt_b = pb;
        repeat (len) @(negedge clk);
        chan_in = '0; pmt_a = 0; pmt_b = 0;
        repeat (6) @(negedge clk);
    endtask

    task automatic vetoed(input int src);
        @(negedge clk);
        if (src == 0) dead_in = 1; else if (src == 1) adc_busy = 1; else qdc_busy = 1;
        repeat (4) @(negedge clk);
        chan_in = 17'(1) << 5;
        repeat (3) @(negedge clk);
        dead_in = 0; adc_busy = 0; qdc_busy = 0;
        repeat (5) @(negedge clk);
        chan_in = '0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R11 trig_raw after reset", int'(trig_raw), 0);
        check("R11 trig_out after reset", int'(trig_out), 0);
        check("R11 trig_ds after reset", int'(trig_ds), 0);
        check("R11 veto_out after reset", int'(veto_out), 0);

        // R11: control 0 disables; raw still follows channels (R2, R3)
        zero_counts();
        hit(17'(1) << 3, 0, 0, 3);
        check("R3 no trigger while disabled", n_trig, 0);
        check("R2 raw edge while disabled", n_raw, 1);

        // R11 default mask all ones: highest channel triggers
        wr(2'd0, C_EN);
        zero_counts();
        hit(17'(1) << 16, 0, 0, 2);
        check("R11 default mask passes channel 16", n_trig, 1);
        check("R9 factor 1 default passes every trigger", n_ds, 1);

        // R8: held input gives one pulse; two separate edges give two
        zero_counts();
        hit(17'(1) << 3, 0, 0, 12);
        check("R8 held input single trigger", n_trig, 1);
        zero_counts();
        hit(17'(1) << 2, 0, 0, 1);
        hit(17'(1) << 7, 0, 0, 1);
        check("R8 two edges two triggers", n_trig, 2);

        // R1: masked channel ignored
        wr(2'd1, ~(32'h1 << 3));
        zero_counts();
        hit(17'(1) << 3, 0, 0, 3);
        check("R1 masked channel no trigger", n_trig, 0);
        check("R1 masked channel no raw", n_raw, 0);
        zero_counts();
        hit(17'(1) << 4, 0, 0, 3);
        check("R1 unmasked neighbour triggers", n_trig, 1);
        wr(2'd1, 32'hFFFF_FFFF);

        // R4: each veto source blocks the edge
        for (int s = 0; s < 3; s++) begin
            zero_counts();
            vetoed(s);
            check("R4 vetoed edge lost", n_trig, 0);
            check("R2 raw ignores veto", n_raw, 1);
        end

        // R7 / R6: photomultiplier term
        zero_counts();
        hit('0, 1, 1, 3);
        check("R7 pmt term not allowed", n_trig, 0);
        wr(2'd0, C_EN | C_PA);
        zero_counts();
        hit('0, 1, 0, 3);
        check("R6 AND mode one pmt no trigger", n_trig, 0);
        zero_counts();
        hit('0, 1, 1, 3);
        check("R6 AND mode both pmts trigger", n_trig, 1);
        wr(2'd0, C_EN | C_PA | C_POR);
        zero_counts();
        hit('0, 0, 1, 3);
        check("R6 OR mode one pmt triggers", n_trig, 1);
        check("R2 raw ignores pmt term", n_raw, 0);

        // R9: downscaling
        wr(2'd2, 32'd3);
        wr(2'd0, C_EN | C_CLR);
        zero_counts();
        for (int i = 0; i < 7; i++) hit(17'(1) << 1, 0, 0, 2);
        check("R9 factor 3 over 7 triggers", n_ds, 2);
        check("R9 triggers counted", n_trig, 7);
        wr(2'd2, 32'd0);
        zero_counts();
        for (int i = 0; i < 3; i++) hit(17'(1) << 1, 0, 0, 2);
        check("R9 factor 0 passes all", n_ds, 3);

        // R10: clear strobe restarts the count and is not stored
        wr(2'd2, 32'd4);
        wr(2'd0, C_EN | C_CLR);
        zero_counts();
        for (int i = 0; i < 3; i++) hit(17'(1) << 6, 0, 0, 2);
        wr(2'd0, C_EN | C_CLR);
        for (int i = 0; i < 3; i++) hit(17'(1) << 6, 0, 0, 2);
        check("R10 cleared count gives no output", n_ds, 0);
        check("R10 enable kept after strobe", n_trig, 6);
        hit(17'(1) << 6, 0, 0, 2);
        check("R10 fourth after clear emits", n_ds, 1);

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule